// File: doc/BRIEF.md
# Line Overhead Byte Inserter

This transmit-side stage rewrites a few transport overhead bytes of an outgoing STS-1 or STS-3/STM-1 frame as they stream past. A framer upstream walks the frame one byte per clock. It tags each byte with a slot code that names the overhead position it occupies. This block replaces the content of the tagged positions and registers every byte, whether or not it was replaced, with one clock of latency.

Each rewritten byte picks its source in priority order. The sync status byte (S1) takes a host register first, then the last byte received on the serial overhead access channel, then a fill pattern. The fill pattern is all zeros or all ones. The APS bytes (K1 and the upper five bits of K2) take a 13-bit host register, or the fill pattern when the register source is disabled. The line remote error indication (REI-L) carries the receive-side B2 block error count, saturated to fit. In STS-3 mode it is written into M1. In STS-1 mode it is written into the low nibble of M0. The count can come from the local receiver or from a protection board. Automatic insertion can be inhibited, and a host-driven error-injection path can replace it.

The block also checks parity on every access-channel byte. A parity failure sets a sticky status bit, which drives an interrupt that can be masked.

Top module: `lor_oh_inserter`

## Requirements
- R1: On an S1 slot (slot code 1) with `host_s1_en_i`=1, the output byte equals `host_s1_val_i`.
- R2: On an S1 slot with `host_s1_en_i`=0 and `toac_s1_en_i`=1, the output is the most recent access-channel byte accepted with `toac_valid_i`=1 before that slot's clock edge (0 after reset).
- R3: On an S1 slot with both S1 enables at 0, the output is 8'h00 if `fill_ones_i`=0 and 8'hFF if it is 1.
- R4: With `aps_en_i`=1, a K1 slot (code 2) outputs `aps_val_i[12:5]`. A K2 slot (code 3) outputs `{aps_val_i[4:0], byte_i[2:0]}`.
- R5: With `aps_en_i`=0, K1 takes the fill byte and K2 bits 7:3 take the fill value. K2 bits 2:0 still pass through.
- R6: With `sts3_i`=1, an M1 slot (code 5) under automatic insertion outputs the error count, saturated at 255. An M0 slot (code 4) passes through unchanged.
- R7: With `sts3_i`=0, an M0 slot outputs `{byte_i[7:4], min(count,8)}`. An M1 slot passes through unchanged.
- R8: With `rei_inh_i`=1 and `rei_errins_en_i`=0, the active REI slot passes through unchanged.
- R9: With `rei_errins_en_i`=1, the active REI slot reports 1 error if at least one `err_strobe_i` pulse arrived since the last such slot, and 0 otherwise. Each report consumes the pending pulse.
- R10: `prot_sel_i`=1 takes the count from `cnt_prot_i`; `prot_sel_i`=0 takes it from `cnt_loc_i`.
- R11: An access-channel byte fails parity when the 9-bit XOR of `{toac_byte_i, toac_par_i}` equals `par_even_i`. Here `par_even_i`=0 selects odd parity and 1 selects even parity. A failure sets `par_err_o`, which stays set until a `par_clr_i` pulse clears it. A new failure wins over a clear in the same cycle.
- R12: `irq_o` equals `par_err_o & ~par_mask_i`.
- R13: Bytes that are not in an active overhead slot (including those with `slot_valid_i`=0) pass to `byte_o` one cycle later. `valid_o` follows `slot_valid_i` one cycle later. In reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_valid_i | input | 1 | Byte on byte_i is valid |
| slot_i | input | 3 | Slot code: 0 other, 1 S1, 2 K1, 3 K2, 4 M0, 5 M1 |
| byte_i | input | 8 | Incoming frame byte |
| sts3_i | input | 1 | 1 selects STS-3/STM-1, 0 selects STS-1 |
| fill_ones_i | input | 1 | Fill pattern: 0 all zeros, 1 all ones |
| host_s1_en_i | input | 1 | S1 taken from host register |
| host_s1_val_i | input | 8 | Host S1 value |
| toac_s1_en_i | input | 1 | S1 taken from access channel |
| aps_en_i | input | 1 | APS bytes taken from host register |
| aps_val_i | input | 13 | K1 and upper K2 bits |
| rei_inh_i | input | 1 | Inhibit automatic REI-L |
| rei_errins_en_i | input | 1 | Enable REI error injection |
| err_strobe_i | input | 1 | Error-injection strobe |
| prot_sel_i | input | 1 | Take count from protection board |
| cnt_loc_i | input | CNT_W | Local B2 error count |
| cnt_prot_i | input | CNT_W | Protection-board B2 error count |
| toac_valid_i | input | 1 | Access-channel byte valid |
| toac_byte_i | input | 8 | Access-channel byte |
| toac_par_i | input | 1 | Access-channel parity bit |
| par_even_i | input | 1 | Parity type: 0 odd, 1 even |
| par_mask_i | input | 1 | Interrupt mask |
| par_clr_i | input | 1 | Clear parity status (write-one pulse) |
| byte_o | output | 8 | Outgoing frame byte |
| valid_o | output | 1 | Outgoing byte valid |
| par_err_o | output | 1 | Sticky parity error status |
| irq_o | output | 1 | Parity interrupt |

## Verification
The bench builds the block with `CNT_W` = 10. At that width a count can exceed 255, so the M1 saturation boundary is reachable, and counts of 255, 256 and 1023 can be driven alongside the STS-1 cap of 8. A 10-bit count also keeps the protection and local sources distinct above the 8-bit range. This separates a mux mistake from a saturation mistake.

// File: rtl/lor_pkg.sv
package lor_pkg;
  typedef enum logic [2:0] {
    SLOT_NONE = 3'd0,
    SLOT_S1   = 3'd1,
    SLOT_K1   = 3'd2,
    SLOT_K2   = 3'd3,
    SLOT_M0   = 3'd4,
    SLOT_M1   = 3'd5
  } slot_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned APS_W  = 13;
endpackage

// File: rtl/lor_toac_rx.sv
module lor_toac_rx
  import lor_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              toac_valid_i,
  input  logic [BYTE_W-1:0] toac_byte_i,
  input  logic              toac_par_i,
  input  logic              par_even_i,
  input  logic              par_mask_i,
  input  logic              par_clr_i,
  output logic [BYTE_W-1:0] toac_q_o,
  output logic              par_err_o,
  output logic              irq_o
);
  logic par_fail;
  logic sts_q;

  // odd parity wants an odd 9-bit XOR, even parity an even one
  assign par_fail = toac_valid_i && ((^{toac_byte_i, toac_par_i}) == par_even_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      toac_q_o <= '0;
      sts_q    <= 1'b0;
    end else begin
      if (toac_valid_i) toac_q_o <= toac_byte_i;
      sts_q <= par_fail | (sts_q & ~par_clr_i);
    end
  end

  assign par_err_o = sts_q;
  assign irq_o     = sts_q & ~par_mask_i;
endmodule

// File: rtl/lor_rei_gen.sv
module lor_rei_gen
  import lor_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sts3_i,
  input  logic              prot_sel_i,
  input  logic [CNT_W-1:0]  cnt_loc_i,
  input  logic [CNT_W-1:0]  cnt_prot_i,
  input  logic              errins_en_i,
  input  logic              err_strobe_i,
  input  logic              consume_i,
  output logic [BYTE_W-1:0] rei_o
);
  localparam logic [31:0] MAX_M1 = 32'd255;
  localparam logic [31:0] MAX_M0 = 32'd8;

  logic [CNT_W-1:0]  cnt_sel;
  logic [31:0]       cnt_w;
  logic [BYTE_W-1:0] sat_val;
  logic              pend_q;

  assign cnt_sel = prot_sel_i ? cnt_prot_i : cnt_loc_i;
  assign cnt_w   = 32'(cnt_sel);

  always_comb begin
    if (sts3_i) sat_val = (cnt_w > MAX_M1) ? 8'hFF : cnt_w[BYTE_W-1:0];
    else        sat_val = (cnt_w > MAX_M0) ? 8'd8  : cnt_w[BYTE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= err_strobe_i | (pend_q & ~consume_i);
  end

  assign rei_o = errins_en_i ? {7'd0, pend_q} : sat_val;
endmodule

// File: rtl/lor_oh_inserter.sv
module lor_oh_inserter
  import lor_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_valid_i,
  input  logic [2:0]        slot_i,
  input  logic [7:0]        byte_i,
  input  logic              sts3_i,
  input  logic              fill_ones_i,
  input  logic              host_s1_en_i,
  input  logic [7:0]        host_s1_val_i,
  input  logic              toac_s1_en_i,
  input  logic              aps_en_i,
  input  logic [12:0]       aps_val_i,
  input  logic              rei_inh_i,
  input  logic              rei_errins_en_i,
  input  logic              err_strobe_i,
  input  logic              prot_sel_i,
  input  logic [CNT_W-1:0]  cnt_loc_i,
  input  logic [CNT_W-1:0]  cnt_prot_i,
  input  logic              toac_valid_i,
  input  logic [7:0]        toac_byte_i,
  input  logic              toac_par_i,
  input  logic              par_even_i,
  input  logic              par_mask_i,
  input  logic              par_clr_i,
  output logic [7:0]        byte_o,
  output logic              valid_o,
  output logic              par_err_o,
  output logic              irq_o
);
  slot_e             slot;
  logic [BYTE_W-1:0] fill, toac_q, rei_val, nxt_byte;
  logic              rei_slot, consume;

  assign slot     = slot_e'(slot_i);
  assign fill     = {BYTE_W{fill_ones_i}};
  assign rei_slot = slot_valid_i && (sts3_i ? (slot == SLOT_M1) : (slot == SLOT_M0));
  assign consume  = rei_slot && rei_errins_en_i;

  lor_toac_rx u_toac (
    .clk_i, .rst_ni, .toac_valid_i, .toac_byte_i, .toac_par_i,
    .par_even_i, .par_mask_i, .par_clr_i,
    .toac_q_o (toac_q), .par_err_o, .irq_o
  );

  lor_rei_gen #(.CNT_W(CNT_W)) u_rei (
    .clk_i, .rst_ni, .sts3_i, .prot_sel_i, .cnt_loc_i, .cnt_prot_i,
    .errins_en_i (rei_errins_en_i), .err_strobe_i,
    .consume_i (consume), .rei_o (rei_val)
  );

  always_comb begin
    nxt_byte = byte_i;
    if (slot_valid_i) begin
      unique case (slot)
        SLOT_S1: nxt_byte = host_s1_en_i ? host_s1_val_i :
                            toac_s1_en_i ? toac_q : fill;
        SLOT_K1: nxt_byte = aps_en_i ? aps_val_i[12:5] : fill;
        SLOT_K2: nxt_byte = {(aps_en_i ? aps_val_i[4:0] : fill[7:3]), byte_i[2:0]};
        default: nxt_byte = byte_i;
      endcase
    end
    if (rei_slot && (rei_errins_en_i || !rei_inh_i))
      nxt_byte = sts3_i ? rei_val : {byte_i[7:4], rei_val[3:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      byte_o  <= nxt_byte;
      valid_o <= slot_valid_i;
    end
  end
endmodule

// File: rtl/lor_oh_inserter_chk.sv
module lor_oh_inserter_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slot_valid_i,
  input logic [2:0]       slot_i,
  input logic [7:0]       byte_i,
  input logic             sts3_i,
  input logic             host_s1_en_i,
  input logic [7:0]       host_s1_val_i,
  input logic             rei_inh_i,
  input logic             rei_errins_en_i,
  input logic             prot_sel_i,
  input logic [CNT_W-1:0] cnt_loc_i,
  input logic             par_mask_i,
  input logic             par_clr_i,
  input logic [7:0]       byte_o,
  input logic             valid_o,
  input logic             par_err_o,
  input logic             irq_o
);
  assert_host_s1_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_i && slot_i == 3'd1 && host_s1_en_i |=> byte_o == $past(host_s1_val_i));

  assert_m1_sat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_i && slot_i == 3'd5 && sts3_i && !rei_inh_i && !rei_errins_en_i &&
    !prot_sel_i && 32'(cnt_loc_i) > 32'd255 |=> byte_o == 8'hFF);

  assert_m0_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_i && slot_i == 3'd4 && !sts3_i |=> byte_o[7:4] == $past(byte_i[7:4]));

  assert_inhibit_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_valid_i && slot_i == (sts3_i ? 3'd5 : 3'd4) && rei_inh_i && !rei_errins_en_i
    |=> byte_o == $past(byte_i));

  assert_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o && !par_clr_i |=> par_err_o);

  assert_irq_mask_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> par_err_o && !par_mask_i);

  assert_valid_lat_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(slot_valid_i));
endmodule

bind lor_oh_inserter lor_oh_inserter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .slot_valid_i, .slot_i, .byte_i, .sts3_i, .host_s1_en_i,
  .host_s1_val_i, .rei_inh_i, .rei_errins_en_i, .prot_sel_i, .cnt_loc_i,
  .par_mask_i, .par_clr_i, .byte_o, .valid_o, .par_err_o, .irq_o
);

// File: tb/test_lor_oh_inserter.sv
module test_lor_oh_inserter;
  localparam int CW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_valid = 0; logic [2:0] slot = 0; logic [7:0] byte_in = 0;
  logic sts3 = 0, fill_ones = 0, host_en = 0, toac_en = 0, aps_en = 0;
  logic [7:0] host_val = 0; logic [12:0] aps_val = 0;
  logic inh = 0, errins = 0, strobe = 0, prot = 0;
  logic [CW-1:0] cloc = 0, cprot = 0;
  logic tvalid = 0, tpar = 0, peven = 0, pmask = 0, pclr = 0; logic [7:0] tbyte = 0;
  logic [7:0] byte_o; logic valid_o, par_err_o, irq_o;

  int checks = 0, fails = 0;
  bit done = 0;
  // reference state
  logic [7:0] m_toac = 0; bit m_pend = 0, m_sts = 0;

  always #2.5 clk = ~clk;

  lor_oh_inserter #(.CNT_W(CW)) i_lor_oh_inserter (
    .clk_i(clk), .rst_ni(rst_n), .slot_valid_i(slot_valid), .slot_i(slot), .byte_i(byte_in),
    .sts3_i(sts3), .fill_ones_i(fill_ones), .host_s1_en_i(host_en), .host_s1_val_i(host_val),
    .toac_s1_en_i(toac_en), .aps_en_i(aps_en), .aps_val_i(aps_val), .rei_inh_i(inh),
    .rei_errins_en_i(errins), .err_strobe_i(strobe), .prot_sel_i(prot), .cnt_loc_i(cloc),
    .cnt_prot_i(cprot), .toac_valid_i(tvalid), .toac_byte_i(tbyte), .toac_par_i(tpar),
    .par_even_i(peven), .par_mask_i(pmask), .par_clr_i(pclr),
    .byte_o(byte_o), .valid_o(valid_o), .par_err_o(par_err_o), .irq_o(irq_o));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: predict, advance, compare
  task automatic step(string req);
    logic [7:0] fill, e_byte; int cnt, v; bit rei_slot, cons, bad;
    fill = fill_ones ? 8'hFF : 8'h00;
    e_byte = byte_in;
    rei_slot = slot_valid && (sts3 ? slot == 5 : slot == 4);
    if (slot_valid) begin
      if (slot == 1) e_byte = host_en ? host_val : (toac_en ? m_toac : fill);
      if (slot == 2) e_byte = aps_en ? aps_val[12:5] : fill;
      if (slot == 3) e_byte = {(aps_en ? aps_val[4:0] : fill[7:3]), byte_in[2:0]};
    end
    cons = rei_slot && errins;
    if (rei_slot && (errins || !inh)) begin
      if (errins) v = m_pend ? 1 : 0;
      else begin
        cnt = prot ? int'(cprot) : int'(cloc);
        v = sts3 ? (cnt > 255 ? 255 : cnt) : (cnt > 8 ? 8 : cnt);
      end
      e_byte = sts3 ? v[7:0] : {byte_in[7:4], v[3:0]};
    end
    bad = tvalid && (($countones({tbyte, tpar}) % 2 == 1) == peven);
    @(posedge clk);
    m_pend = strobe || (m_pend && !cons);
    m_sts  = bad || (m_sts && !pclr);
    if (tvalid) m_toac = tbyte;
    #1;
    check(req, {24'd0, byte_o}, {24'd0, e_byte});
    check({req, " valid"}, {31'd0, valid_o}, {31'd0, slot_valid});
    check("R11 status", {31'd0, par_err_o}, {31'd0, m_sts});
    check("R12 irq", {31'd0, irq_o}, {31'd0, m_sts && !pmask});
  endtask

  task automatic put(logic [2:0] s, logic [7:0] b);
    slot_valid = 1; slot = s; byte_in = b;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #7;
    // R13 reset state
    check("R13 reset byte", {24'd0, byte_o}, 0);
    check("R13 reset valid", {31'd0, valid_o}, 0);
    check("R13 reset irq", {30'd0, par_err_o, irq_o}, 0);
    rst_n = 1;
    @(negedge clk);

    // R13 plain bytes and unused slot
    put(0, 8'hA5); step("R13 pass");
    slot_valid = 0; byte_in = 8'h3C; step("R13 invalid");

    // S1 sources: R1, R2, R3
    tvalid = 1; tbyte = 8'h5A; tpar = 1; peven = 0; step("R2 load");
    tvalid = 0;
    host_en = 1; host_val = 8'h0F; toac_en = 1; put(1, 8'h77); step("R1 host");
    host_en = 0; step("R2 toac");
    toac_en = 0; fill_ones = 0; step("R3 zeros");
    fill_ones = 1; step("R3 ones");

    // APS: R4, R5
    aps_en = 1; aps_val = 13'h1ABC; put(2, 8'h11); step("R4 K1");
    put(3, 8'hF5); step("R4 K2");
    aps_en = 0; fill_ones = 0; put(2, 8'h99); step("R5 K1 fill");
    fill_ones = 1; put(3, 8'h02); step("R5 K2 fill");

    // STS-3: R6, R10
    sts3 = 1; cloc = 10'd200; put(5, 8'h00); step("R6 count");
    cloc = 10'd255; step("R6 at 255");
    cloc = 10'd256; step("R6 sat 256");
    cloc = 10'd1023; step("R6 sat max");
    put(4, 8'h6B); step("R6 M0 pass");
    prot = 1; cprot = 10'd3; cloc = 10'd40; put(5, 8'h00); step("R10 prot");
    prot = 0; step("R10 local");

    // STS-1: R7
    sts3 = 0; cloc = 10'd5; put(4, 8'hC0); step("R7 count");
    cloc = 10'd9; put(4, 8'hAF); step("R7 sat");
    cloc = 10'd300; step("R7 sat big");
    put(5, 8'h44); step("R7 M1 pass");

    // R8 inhibit
    inh = 1; put(4, 8'h3E); step("R8 sts1");
    sts3 = 1; put(5, 8'hD2); step("R8 sts3");

    // R9 injection
    errins = 1; slot_valid = 0; strobe = 1; step("R9 strobe");
    strobe = 0; put(5, 8'h55); step("R9 one");
    step("R9 consumed");
    slot_valid = 0; strobe = 1; step("R9 strobe a");
    step("R9 strobe b");
    strobe = 0; put(5, 8'h55); step("R9 once");
    step("R9 zero");
    errins = 0; inh = 0;

    // R11/R12 parity
    slot_valid = 0;
    tvalid = 1; tbyte = 8'h01; tpar = 1; peven = 0; step("R11 odd bad");
    tvalid = 0; step("R11 sticky");
    pmask = 1; step("R12 masked");
    pmask = 0; pclr = 1; step("R11 clear");
    pclr = 0; tvalid = 1; tbyte = 8'h01; tpar = 1; peven = 1; step("R11 even ok");
    tpar = 0; step("R11 even bad");
    pclr = 1; tpar = 0; step("R11 set wins");
    pclr = 1; tvalid = 0; step("R11 cleared");
    pclr = 0;
    // R2 value latched while parity failed
    toac_en = 1; put(1, 8'h00); step("R2 latest");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule